// File: doc/BRIEF.md
# Pairwise-Age LRU Victim Selector

This block holds the replacement state for a four-way set-associative cache. Each set keeps a six-bit vector with one bit per pair of ways. A bit records which way of its pair was used longer ago. When the cache reports a hit or a fill on a way, that way becomes the most recent in its set. On a miss, the cache reads the vector of the missed set and decodes it into the way to evict. That way is the one older than all three of the others.

Software may overwrite the vector of any set with a raw six-bit value. Only the 24 patterns that describe a strict ordering of the four ways give a meaningful victim. Other patterns are not detected. The update port, the software write port and the victim read port each carry their own set index, so all three can act in one cycle.

Top module: `lru_pair_sel`

## Requirements
- R1: The block stores one six-bit vector for each of `NUM_SETS` sets. `vic_way_o` is a combinational decode of the vector of the set on `vic_set_i`. It shows the state as of the last rising clock edge.
- R2: While `rst_ni` is low, every vector is cleared to 000000, so every set reports victim way 3.
- R3: Each vector bit orders one pair of ways. Bit 5 orders ways 0/1, bit 4 orders 0/2, bit 3 orders 0/3, bit 2 orders 1/2, bit 1 orders 1/3 and bit 0 orders 2/3. A value of 1 means the lower-numbered way of the pair is older.
- R4: An access (`acc_valid_i` high) to way k of a set sets every bit that pairs k with a lower-numbered way. It clears every bit that pairs k with a higher-numbered way and leaves the other bits unchanged. The new vector is visible after the next rising edge, and way k is then never the victim.
- R5: The victim is decoded as follows:
  - way 0 when bits 5,4,3 are 111;
  - way 1 when bit 5 is 0 and bits 2,1 are 11;
  - way 2 when bits 4 and 2 are 0 and bit 0 is 1;
  - way 3 when bits 3,1,0 are 000.
- R6: Each of the 24 legal patterns selects its victim:
  - 000000, 000100, 010100, 100000, 110000 and 110100 select way 3;
  - 000001, 000011, 001011, 100001, 101001 and 101011 select way 2;
  - 000110, 000111, 001111, 010110, 011110 and 011111 select way 1;
  - 111000, 111001, 111011, 111100, 111110 and 111111 select way 0.
- R7: A software write (`sw_we_i` high) replaces the whole vector of `sw_set_i` with `sw_data_i` at the next rising edge.
- R8: When a software write and an access target the same set in the same cycle, the written value is stored and the access is discarded.
- R9: An access or a write changes only its own set. A write to one set and an access to another set in the same cycle both take effect.
- R10: In a cycle with neither an access nor a write, no vector changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Way access strobe (hit or fill) |
| acc_set_i | input | SET_W | Set index of the access |
| acc_way_i | input | 2 | Way that was accessed |
| sw_we_i | input | 1 | Software write strobe |
| sw_set_i | input | SET_W | Set index of the software write |
| sw_data_i | input | 6 | Raw vector to store |
| vic_set_i | input | SET_W | Set index whose victim is requested |
| vic_way_o | output | 2 | Victim way for `vic_set_i` |

## Verification
A wrong bit in a stored vector shows up only through the victim decode. The ports see it the next time that set is read, one edge after the update. The error may stay hidden while the victim is unchanged, then appear after later accesses have moved the corrupt bit into the decision. For that reason the checks compare the victim after every single access, over long mixed sequences. A lost or misdirected update shows at once as a victim equal to the way just used. A write that leaks into the wrong set shows as a changed victim on a set that should have held still.

// File: rtl/lru_pair_pkg.sv
package lru_pair_pkg;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = 2;
  localparam int AGE_W    = NUM_WAYS * (NUM_WAYS - 1) / 2;

  typedef logic [AGE_W-1:0] age_vec_t;
  typedef logic [WAY_W-1:0] way_t;

  // Lower-numbered way of the pair held in bit b.
  function automatic int pair_lo(int b);
    case (b)
      5, 4, 3: return 0;
      2, 1:    return 1;
      default: return 2;
    endcase
  endfunction

  // Higher-numbered way of the pair held in bit b.
  function automatic int pair_hi(int b);
    case (b)
      5:       return 1;
      4, 2:    return 2;
      default: return 3;
    endcase
  endfunction

  // Bit index of the pair (a,b), where a < b.
  function automatic int pair_bit(int a, int b);
    if (a == 0) return 6 - b;
    if (a == 1) return 4 - b;
    return 0;
  endfunction
endpackage

// File: rtl/lru_age_update.sv
module lru_age_update
  import lru_pair_pkg::*;
(
  input  age_vec_t cur_i,
  input  way_t     way_i,
  output age_vec_t nxt_o
);
  for (genvar b = 0; b < AGE_W; b++) begin : g_bit
    localparam int LO = pair_lo(b);
    localparam int HI = pair_hi(b);
    always_comb begin
      if (way_i == WAY_W'(HI))      nxt_o[b] = 1'b1;  // partner LO is now older
      else if (way_i == WAY_W'(LO)) nxt_o[b] = 1'b0;  // partner HI is now older
      else                          nxt_o[b] = cur_i[b];
    end
  end
endmodule

// File: rtl/lru_victim_dec.sv
module lru_victim_dec
  import lru_pair_pkg::*;
(
  input  age_vec_t vec_i,
  output way_t     way_o
);
  logic [NUM_WAYS-1:0] oldest;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [NUM_WAYS-1:0] older;
    for (genvar o = 0; o < NUM_WAYS; o++) begin : g_oth
      if (o == w) begin : g_self
        assign older[o] = 1'b1;
      end else if (w < o) begin : g_lo
        assign older[o] = vec_i[pair_bit(w, o)];
      end else begin : g_hi
        assign older[o] = ~vec_i[pair_bit(o, w)];
      end
    end
    assign oldest[w] = &older;
  end

  always_comb begin
    way_o = WAY_W'(NUM_WAYS - 1);
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (oldest[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/lru_pair_sel.sv
module lru_pair_sel
  import lru_pair_pkg::*;
#(
  parameter int NUM_SETS = 64,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic [SET_W-1:0] acc_set_i,
  input  logic [1:0]       acc_way_i,
  input  logic             sw_we_i,
  input  logic [SET_W-1:0] sw_set_i,
  input  logic [5:0]       sw_data_i,
  input  logic [SET_W-1:0] vic_set_i,
  output logic [1:0]       vic_way_o
);
  age_vec_t [NUM_SETS-1:0] age_q;
  age_vec_t                acc_nxt;

  lru_age_update u_upd (
    .cur_i (age_q[acc_set_i]),
    .way_i (acc_way_i),
    .nxt_o (acc_nxt)
  );

  lru_victim_dec u_dec (
    .vec_i (age_q[vic_set_i]),
    .way_o (vic_way_o)
  );

  // The software write is assigned last, so it wins on a same-set collision.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
    end else begin
      if (acc_valid_i) age_q[acc_set_i] <= acc_nxt;
      if (sw_we_i)     age_q[sw_set_i]  <= sw_data_i;
    end
  end

  p_fresh_not_victim_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !(sw_we_i && sw_set_i == acc_set_i) && vic_set_i == acc_set_i)
      |=> ($past(vic_set_i) != vic_set_i) || (vic_way_o != $past(acc_way_i)));

  p_sw_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> age_q[$past(sw_set_i)] == $past(sw_data_i));

  p_sw_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && acc_valid_i && sw_set_i == acc_set_i)
      |=> age_q[$past(acc_set_i)] == $past(sw_data_i));

  p_other_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(acc_valid_i && acc_set_i == vic_set_i) && !(sw_we_i && sw_set_i == vic_set_i))
      |=> ($past(vic_set_i) != vic_set_i) || $stable(vic_way_o));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i && !sw_we_i) |=> $stable(age_q));
endmodule

// File: tb/lru_pair_sel_tb_top.sv
`timescale 1ns/1ps
module lru_pair_sel_tb_top;
  localparam int NS = 64;
  localparam int SW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          acc_valid_i, sw_we_i;
  logic [SW-1:0] acc_set_i, sw_set_i, vic_set_i;
  logic [1:0]    acc_way_i, vic_way_o;
  logic [5:0]    sw_data_i;

  always #4 clk = ~clk;

  lru_pair_sel #(.NUM_SETS(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i), .acc_set_i(acc_set_i),
    .acc_way_i(acc_way_i), .sw_we_i(sw_we_i), .sw_set_i(sw_set_i), .sw_data_i(sw_data_i),
    .vic_set_i(vic_set_i), .vic_way_o(vic_way_o)
  );

  localparam logic [5:0] PAT [24] = '{
    6'b000000, 6'b000100, 6'b010100, 6'b100000, 6'b110000, 6'b110100,
    6'b000001, 6'b000011, 6'b001011, 6'b100001, 6'b101001, 6'b101011,
    6'b000110, 6'b000111, 6'b001111, 6'b010110, 6'b011110, 6'b011111,
    6'b111000, 6'b111001, 6'b111011, 6'b111100, 6'b111110, 6'b111111};

  int         n_chk = 0, n_fail = 0;
  int         q_set[$], q_exp[$];
  string      q_tag[$];
  logic [5:0] mdl [NS];
  bit         done = 0;

  function automatic int tab_victim(logic [5:0] v);
    for (int i = 0; i < 24; i++) if (PAT[i] == v) return 3 - i / 6;
    return -1;
  endfunction

  // Model of R3/R4: bit -> pair (lo,hi), 1 = lo older.
  function automatic logic [5:0] mdl_upd(logic [5:0] v, int k);
    int lo [6] = '{2, 1, 1, 0, 0, 0};
    int hi [6] = '{3, 3, 2, 3, 2, 1};
    logic [5:0] r = v;
    for (int b = 0; b < 6; b++) begin
      if (hi[b] == k) r[b] = 1'b1;
      else if (lo[b] == k) r[b] = 1'b0;
    end
    return r;
  endfunction

  task automatic op(bit av, int as, int aw, bit sv, int ss, logic [5:0] sd);
    @(negedge clk);
    acc_valid_i = av; acc_set_i = SW'(as); acc_way_i = 2'(aw);
    sw_we_i = sv; sw_set_i = SW'(ss); sw_data_i = sd;
    if (av) mdl[as] = mdl_upd(mdl[as], aw);
    if (sv) mdl[ss] = sd;
  endtask

  task automatic chk(int s, string tag);
    @(negedge clk);
    acc_valid_i = 1'b0; sw_we_i = 1'b0; vic_set_i = SW'(s);
    q_set.push_back(s); q_exp.push_back(tab_victim(mdl[s])); q_tag.push_back(tag);
  endtask

  // Monitor: compare the victim 2 ns after each falling edge.
  initial forever begin
    @(negedge clk);
    #2;
    if (q_set.size() > 0) begin
      int s, e;
      string t;
      s = q_set.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      n_chk++;
      if (e < 0 || int'(vic_way_o) != e) begin
        n_fail++;
        $display("FAIL %s set=%0d got=%0d exp=%0d", t, s, vic_way_o, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; acc_valid_i = 0; sw_we_i = 0;
    acc_set_i = '0; sw_set_i = '0; vic_set_i = '0; acc_way_i = '0; sw_data_i = '0;
    for (int i = 0; i < NS; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R2: reset state; R1: read port follows vic_set_i each cycle
    chk(0, "R2"); chk(17, "R2"); chk(NS - 1, "R1");

    // R6 and R7: every legal pattern loaded by software
    for (int i = 0; i < 24; i++) begin
      op(0, 0, 0, 1, 1, PAT[i]);
      chk(1, "R6");
    end

    // R3/R4/R5: a walk from reset on set 2
    op(1, 2, 1, 0, 0, '0); chk(2, "R3");  // 100000 -> way 3
    op(1, 2, 3, 0, 0, '0); chk(2, "R4");  // 101011 -> way 2
    op(1, 2, 2, 0, 0, '0); chk(2, "R4");  // 111110 -> way 0
    op(1, 2, 0, 0, 0, '0); chk(2, "R5");  // 000110 -> way 1
    op(1, 2, 1, 0, 0, '0); chk(2, "R5");  // 100000 -> way 3

    // R8: same-set collision, software value wins
    op(0, 0, 0, 1, 3, 6'b000000); chk(3, "R7");
    op(1, 3, 2, 1, 3, 6'b111111); chk(3, "R8");

    // R9: write set 4 and access set 5 together; set 6 untouched
    op(1, 5, 3, 1, 4, 6'b000110);
    chk(4, "R9"); chk(5, "R9"); chk(6, "R9");

    // R10: idle cycles hold state
    op(0, 0, 0, 0, 0, '0);
    repeat (4) @(negedge clk);
    chk(2, "R10"); chk(4, "R10");

    // R4/R9: mixed random traffic over a few sets
    for (int n = 0; n < 400; n++) begin
      int s, w, ws;
      bit dw;
      s = int'($urandom_range(0, 7)); w = int'($urandom_range(0, 3));
      dw = ($urandom_range(0, 4) == 0); ws = int'($urandom_range(0, 7));
      op(1, s, w, dw, ws, PAT[$urandom_range(0, 23)]);
      chk(s, "R4");
      if (dw && ws != s) chk(ws, "R9");
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule